// File: doc/BRIEF.md
# TCP Segmentation Header Updater

This block does the per-segment accounting for transmit-side TCP segmentation. A context load sets the header length and the maximum segment size (MSS). A data descriptor that carries the segmentation-enable flag then starts a segmentation run, and the total payload length arrives with it. On each cycle that a descriptor is present during a run, the block issues one copy command. The command gives how many payload bytes to take from the current descriptor, the offset into that descriptor, and whether the saved header must be placed first.

When a command fills a segment to MSS plus header, or uses up the total payload, the block closes the segment. In the same cycle it reports the header fix-ups for that segment: an IP identification increment, the IP total length, a TCP sequence increment and a TCP flag mask. A downstream engine applies these. Checksums and the data movement itself are handled elsewhere. The block pops a descriptor once its bytes are used up. A segment can span several descriptors, and one descriptor can feed several segments.

Top module: `tso_seg_updater`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `cmd_valid`, `desc_pop` and `seg_valid` are low.
- R2: A `ctx_valid` pulse while idle captures `ctx_hdr_len` and `ctx_mss` at the clock edge. A pulse while busy has no effect, so the copy sizes of the run in progress keep using the old values.
- R3: While idle, a present descriptor with `desc_seg_en`=1 starts a run. `busy` rises on the next cycle, and the used-payload, descriptor-offset, segment-index and previous-sequence counters all restart at 0. No command and no pop occur in the starting cycle.
- R4: While idle, a present descriptor with `desc_seg_en`=0 is popped in the same cycle and produces no command.
- R5: While busy with a descriptor present, `cmd_copy` = min(MSS, desc_len − offset) when the segment has no header yet, and min(MSS + hdr − seg_len, desc_len − offset) when it has one.
- R6: `cmd_hdr` is 1 exactly when the segment has no header yet. `cmd_size` = `cmd_copy` plus the header length in that case, and `cmd_copy` otherwise.
- R7: `cmd_offset` gives the bytes already taken from the current descriptor. `desc_pop` is 1 in the cycle in which offset + copy equals `desc_len`, and the offset then restarts at 0.
- R8: `seg_valid` is 1 when the new segment length reaches MSS + hdr or the used payload equals the total. Otherwise the segment stays open.
- R9: `fix_id_inc` equals the index of the closing segment, counting from 0 within the run.
- R10: `fix_ip_len` equals the closing segment's full length (header included) minus 14.
- R11: `fix_seq_inc` equals the payload bytes emitted in earlier segments of the run.
- R12: `fix_flag_mask` is 8'hF6 (clears FIN bit 0 and PSH bit 3) on every closing segment except the last, and 8'hFF on the last. It is 0 when `seg_valid` is low.
- R13: `seg_last` marks the segment whose close makes the used payload equal the total. `busy` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_valid | input | 1 | Context load strobe |
| ctx_hdr_len | input | HDR_W | Header length in bytes |
| ctx_mss | input | LEN_W | Maximum payload bytes per segment |
| desc_valid | input | 1 | A data descriptor is present |
| desc_seg_en | input | 1 | Descriptor requests segmentation (used when idle) |
| desc_len | input | LEN_W | Payload bytes in the descriptor |
| desc_total | input | TOT_W | Total payload of the run (sampled at start) |
| desc_pop | output | 1 | Current descriptor is consumed this cycle |
| busy | output | 1 | A segmentation run is active |
| cmd_valid | output | 1 | Copy command issued this cycle |
| cmd_hdr | output | 1 | Place the saved header before this copy |
| cmd_copy | output | LEN_W | Payload bytes to copy |
| cmd_offset | output | LEN_W | Byte offset into the current descriptor |
| cmd_size | output | LEN_W | Bytes added to the segment by this command |
| seg_valid | output | 1 | The segment closes this cycle |
| seg_last | output | 1 | The closing segment is the final one |
| fix_id_inc | output | IDX_W | Amount to add to the IP identification |
| fix_ip_len | output | LEN_W | New IP total length |
| fix_seq_inc | output | TOT_W | Amount to add to the TCP sequence number |
| fix_flag_mask | output | 8 | AND mask for the TCP flags byte |

## Verification
Command, pop, close and fix-up outputs depend combinationally on the registered run state and on the descriptor presented. They are therefore due in the same cycle as the descriptor. Context loads, run starts and counter updates only take effect after the next rising edge. The bench drives inputs on the falling edge and compares every output a quarter period later against a behavioural model. It then steps that model at the rising edge, so each result is checked in the cycle it is due. Effects of ignored context loads and of run starts are seen through the copy sizes and `busy` on the following cycles.

// File: rtl/tso_seg_pkg.sv
// Shared constants and types for the TCP segmentation header updater.
package tso_seg_pkg;
    localparam int ETH_HDR_BYTES = 14;
    localparam logic [7:0] FLAG_MASK_LAST = 8'hFF;
    localparam logic [7:0] FLAG_MASK_MID  = ~8'd9;

    typedef enum logic {ST_IDLE, ST_SEG} seg_state_e;
endpackage

// File: rtl/tso_copy_calc.sv
// Copy-size calculator: decides how many payload bytes the next command
// takes from the current descriptor and how much the segment grows.
// Assumes mss + hdr_len fits in LEN_W bits and desc_used <= desc_len.
module tso_copy_calc #(
    parameter int LEN_W = 16,
    parameter int HDR_W = 8
) (
    input  logic [LEN_W-1:0] mss,
    input  logic [HDR_W-1:0] hdr_len,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [LEN_W-1:0] desc_used,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             has_hdr,
    output logic [LEN_W-1:0] copy,
    output logic [LEN_W-1:0] size,
    output logic [LEN_W-1:0] new_len
);
    logic [LEN_W-1:0] hdr_ext;
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] remain;

    // Room left in the segment versus bytes left in the descriptor.
    always_comb begin
        hdr_ext = LEN_W'(hdr_len);
        room    = has_hdr ? (mss + hdr_ext - seg_len) : mss;
        remain  = desc_len - desc_used;
        copy    = (room < remain) ? room : remain;
        size    = copy + (has_hdr ? '0 : hdr_ext);
        new_len = seg_len + size;
    end
endmodule

// File: rtl/tso_progress.sv
// Run controller: holds the context, the run state and the byte counters,
// and decides per cycle whether a command issues, a descriptor pops and a
// segment closes. Assumes the descriptor lengths of a run sum to its total.
module tso_progress
    import tso_seg_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int HDR_W = 8,
    parameter int TOT_W = 20,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_valid,
    input  logic [HDR_W-1:0] ctx_hdr_len,
    input  logic [LEN_W-1:0] ctx_mss,
    input  logic             desc_valid,
    input  logic             desc_seg_en,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [TOT_W-1:0] desc_total,
    input  logic [LEN_W-1:0] copy,
    input  logic [LEN_W-1:0] new_len,
    output logic [HDR_W-1:0] hdr_len,
    output logic [LEN_W-1:0] mss,
    output logic [LEN_W-1:0] desc_used,
    output logic [LEN_W-1:0] seg_len,
    output logic             has_hdr,
    output logic [IDX_W-1:0] seg_idx,
    output logic [TOT_W-1:0] prev_seq,
    output logic             active,
    output logic             cmd_go,
    output logic             desc_pop,
    output logic             seg_close,
    output logic             seg_last
);
    seg_state_e       state;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] used;
    logic [TOT_W-1:0] used_next;
    logic             desc_end;
    logic [LEN_W-1:0] seg_full;

    // Per-cycle decisions from the run state and the presented descriptor.
    always_comb begin
        active    = (state == ST_SEG);
        cmd_go    = active && desc_valid;
        used_next = used + TOT_W'(copy);
        desc_end  = ((desc_used + copy) == desc_len);
        seg_full  = mss + LEN_W'(hdr_len);
        seg_last  = cmd_go && (used_next == total);
        seg_close = cmd_go && ((new_len >= seg_full) || (used_next == total));
        desc_pop  = (cmd_go && desc_end) || (!active && desc_valid && !desc_seg_en);
    end

    // Context capture, run start and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hdr_len   <= '0;
            mss       <= '0;
            total     <= '0;
            used      <= '0;
            desc_used <= '0;
            seg_len   <= '0;
            has_hdr   <= 1'b0;
            seg_idx   <= '0;
            prev_seq  <= '0;
        end else if (!active) begin
            if (ctx_valid) begin
                hdr_len <= ctx_hdr_len;
                mss     <= ctx_mss;
            end
            if (desc_valid && desc_seg_en) begin
                state     <= ST_SEG;
                total     <= desc_total;
                used      <= '0;
                desc_used <= '0;
                seg_len   <= '0;
                has_hdr   <= 1'b0;
                seg_idx   <= '0;
                prev_seq  <= '0;
            end
        end else if (cmd_go) begin
            used      <= used_next;
            desc_used <= desc_end ? '0 : (desc_used + copy);
            if (seg_close) begin
                seg_len  <= '0;
                has_hdr  <= 1'b0;
                seg_idx  <= seg_idx + 1'b1;
                prev_seq <= used_next;
            end else begin
                seg_len  <= new_len;
                has_hdr  <= 1'b1;
            end
            if (seg_last) begin
                state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/tso_fixup.sv
// Header fix-up generator: turns the closing segment's index, length and
// prior payload offset into the IP/TCP field updates. Outputs are zero
// when no segment closes. Assumes new_len >= 14 when a segment closes.
module tso_fixup
    import tso_seg_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TOT_W = 20,
    parameter int IDX_W = 8
) (
    input  logic             seg_close,
    input  logic             seg_last,
    input  logic [IDX_W-1:0] seg_idx,
    input  logic [LEN_W-1:0] new_len,
    input  logic [TOT_W-1:0] prev_seq,
    output logic [IDX_W-1:0] fix_id_inc,
    output logic [LEN_W-1:0] fix_ip_len,
    output logic [TOT_W-1:0] fix_seq_inc,
    output logic [7:0]       fix_flag_mask
);
    // Field updates for the segment closing this cycle.
    always_comb begin
        fix_id_inc    = '0;
        fix_ip_len    = '0;
        fix_seq_inc   = '0;
        fix_flag_mask = '0;
        if (seg_close) begin
            fix_id_inc    = seg_idx;
            fix_ip_len    = new_len - LEN_W'(ETH_HDR_BYTES);
            fix_seq_inc   = prev_seq;
            fix_flag_mask = seg_last ? FLAG_MASK_LAST : FLAG_MASK_MID;
        end
    end
endmodule

// File: rtl/tso_seg_updater.sv
// TCP segmentation header updater (top). Issues one copy command per cycle
// while a run is active and a descriptor is present, and reports the header
// fix-ups of each segment in the cycle it closes. Assumes descriptor lengths
// are nonzero, sum to the run total, and mss > 0.
module tso_seg_updater #(
    parameter int LEN_W = 16,
    parameter int HDR_W = 8,
    parameter int TOT_W = 20,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_valid,
    input  logic [HDR_W-1:0] ctx_hdr_len,
    input  logic [LEN_W-1:0] ctx_mss,
    input  logic             desc_valid,
    input  logic             desc_seg_en,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [TOT_W-1:0] desc_total,
    output logic             desc_pop,
    output logic             busy,
    output logic             cmd_valid,
    output logic             cmd_hdr,
    output logic [LEN_W-1:0] cmd_copy,
    output logic [LEN_W-1:0] cmd_offset,
    output logic [LEN_W-1:0] cmd_size,
    output logic             seg_valid,
    output logic             seg_last,
    output logic [IDX_W-1:0] fix_id_inc,
    output logic [LEN_W-1:0] fix_ip_len,
    output logic [TOT_W-1:0] fix_seq_inc,
    output logic [7:0]       fix_flag_mask
);
    logic [HDR_W-1:0] hdr_len;
    logic [LEN_W-1:0] mss;
    logic [LEN_W-1:0] desc_used;
    logic [LEN_W-1:0] seg_len;
    logic             has_hdr;
    logic [IDX_W-1:0] seg_idx;
    logic [TOT_W-1:0] prev_seq;
    logic             active;
    logic             cmd_go;
    logic             seg_close;
    logic             last_int;
    logic [LEN_W-1:0] copy;
    logic [LEN_W-1:0] size;
    logic [LEN_W-1:0] new_len;

    tso_copy_calc #(.LEN_W(LEN_W), .HDR_W(HDR_W)) i_calc (
        .mss(mss), .hdr_len(hdr_len), .desc_len(desc_len),
        .desc_used(desc_used), .seg_len(seg_len), .has_hdr(has_hdr),
        .copy(copy), .size(size), .new_len(new_len)
    );

    tso_progress #(.LEN_W(LEN_W), .HDR_W(HDR_W), .TOT_W(TOT_W), .IDX_W(IDX_W)) i_prog (
        .clk(clk), .rst_n(rst_n),
        .ctx_valid(ctx_valid), .ctx_hdr_len(ctx_hdr_len), .ctx_mss(ctx_mss),
        .desc_valid(desc_valid), .desc_seg_en(desc_seg_en),
        .desc_len(desc_len), .desc_total(desc_total),
        .copy(copy), .new_len(new_len),
        .hdr_len(hdr_len), .mss(mss), .desc_used(desc_used),
        .seg_len(seg_len), .has_hdr(has_hdr), .seg_idx(seg_idx),
        .prev_seq(prev_seq), .active(active), .cmd_go(cmd_go),
        .desc_pop(desc_pop), .seg_close(seg_close), .seg_last(last_int)
    );

    tso_fixup #(.LEN_W(LEN_W), .TOT_W(TOT_W), .IDX_W(IDX_W)) i_fix (
        .seg_close(seg_close), .seg_last(last_int), .seg_idx(seg_idx),
        .new_len(new_len), .prev_seq(prev_seq),
        .fix_id_inc(fix_id_inc), .fix_ip_len(fix_ip_len),
        .fix_seq_inc(fix_seq_inc), .fix_flag_mask(fix_flag_mask)
    );

    // Command outputs, gated to zero when no command issues.
    always_comb begin
        busy       = active;
        cmd_valid  = cmd_go;
        cmd_hdr    = cmd_go && !has_hdr;
        cmd_copy   = cmd_go ? copy : '0;
        cmd_size   = cmd_go ? size : '0;
        cmd_offset = cmd_go ? desc_used : '0;
        seg_valid  = seg_close;
        seg_last   = last_int;
    end
endmodule

// File: rtl/tso_seg_checker.sv
// Protocol checker for tso_seg_updater, attached by bind. Observes ports only.
module tso_seg_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_valid,
    input logic             desc_seg_en,
    input logic [LEN_W-1:0] desc_len,
    input logic             desc_pop,
    input logic             busy,
    input logic             cmd_valid,
    input logic [LEN_W-1:0] cmd_copy,
    input logic [LEN_W-1:0] cmd_offset,
    input logic             seg_valid,
    input logic             seg_last,
    input logic [7:0]       fix_flag_mask
);
    a_r3_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && desc_valid && desc_seg_en) |=> busy);

    a_r4_no_cmd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    a_r5_copy_within_desc: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_copy != '0) &&
                       (({1'b0, cmd_copy} + {1'b0, cmd_offset}) <= {1'b0, desc_len})));

    a_r7_pop_needs_desc: assert property (@(posedge clk) disable iff (!rst_n)
        desc_pop |-> desc_valid);

    a_r7_offset_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && desc_pop) |=> (cmd_offset == '0));

    a_r8_close_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> cmd_valid);

    a_r12_mask_values: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_last ? (fix_flag_mask == 8'hFF) : (fix_flag_mask == 8'hF6)));

    a_r13_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_last) |=> !busy);
endmodule

bind tso_seg_updater tso_seg_checker #(.LEN_W(LEN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_seg_en(desc_seg_en),
    .desc_len(desc_len), .desc_pop(desc_pop), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_copy(cmd_copy), .cmd_offset(cmd_offset), .seg_valid(seg_valid),
    .seg_last(seg_last), .fix_flag_mask(fix_flag_mask)
);

// File: tb/test_tso_seg_updater.sv
module test_tso_seg_updater;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int HDR_W = 8;
    localparam int TOT_W = 20;
    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctx_valid = 1'b0;
    logic [HDR_W-1:0] ctx_hdr_len = '0;
    logic [LEN_W-1:0] ctx_mss = '0;
    logic             desc_valid = 1'b0;
    logic             desc_seg_en = 1'b0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [TOT_W-1:0] desc_total = '0;
    logic             desc_pop, busy, cmd_valid, cmd_hdr, seg_valid, seg_last;
    logic [LEN_W-1:0] cmd_copy, cmd_offset, cmd_size, fix_ip_len;
    logic [IDX_W-1:0] fix_id_inc;
    logic [TOT_W-1:0] fix_seq_inc;
    logic [7:0]       fix_flag_mask;

    tso_seg_updater #(.LEN_W(LEN_W), .HDR_W(HDR_W), .TOT_W(TOT_W), .IDX_W(IDX_W)) i_tso_seg_updater (
        .clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_hdr_len(ctx_hdr_len),
        .ctx_mss(ctx_mss), .desc_valid(desc_valid), .desc_seg_en(desc_seg_en),
        .desc_len(desc_len), .desc_total(desc_total), .desc_pop(desc_pop),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_hdr(cmd_hdr), .cmd_copy(cmd_copy),
        .cmd_offset(cmd_offset), .cmd_size(cmd_size), .seg_valid(seg_valid),
        .seg_last(seg_last), .fix_id_inc(fix_id_inc), .fix_ip_len(fix_ip_len),
        .fix_seq_inc(fix_seq_inc), .fix_flag_mask(fix_flag_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    // Behavioural model state
    bit m_act = 0, m_hh = 0;
    int m_hdr = 0, m_mss = 0, m_tot = 0, m_used = 0, m_dused = 0, m_cur = 0, m_idx = 0, m_prev = 0;
    // Model expectations for the current cycle
    int e_go, e_copy, e_size, e_hdr, e_off, e_pop, e_close, e_last, e_id, e_iplen, e_seq, e_mask, e_nl, e_un;
    int dq[$];
    bit first_pending = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        int room, rem;
        e_go   = (m_act && desc_valid) ? 1 : 0;
        room   = m_hh ? (m_mss + m_hdr - m_cur) : m_mss;
        rem    = int'(desc_len) - m_dused;
        e_copy = (room < rem) ? room : rem;
        e_size = e_copy + (m_hh ? 0 : m_hdr);
        e_nl   = m_cur + e_size;
        e_un   = m_used + e_copy;
        e_last = (e_go && e_un == m_tot) ? 1 : 0;
        e_close = (e_go && (e_nl >= m_mss + m_hdr || e_un == m_tot)) ? 1 : 0;
        e_pop  = ((e_go && (m_dused + e_copy == int'(desc_len))) ||
                  (!m_act && desc_valid && !desc_seg_en)) ? 1 : 0;
        e_hdr  = (e_go && !m_hh) ? 1 : 0;
        e_off  = e_go ? m_dused : 0;
        if (!e_go) begin e_copy = 0; e_size = 0; end
        e_id    = e_close ? m_idx : 0;
        e_iplen = e_close ? e_nl - 14 : 0;
        e_seq   = e_close ? m_prev : 0;
        e_mask  = e_close ? (e_last ? 255 : 246) : 0;
    endtask

    task automatic compare();
        model_eval();
        chk("R1/R3/R13", "busy", int'(busy), int'(m_act));
        chk("R3/R4", "cmd_valid", int'(cmd_valid), e_go);
        chk("R5", "cmd_copy", int'(cmd_copy), e_copy);
        chk("R6", "cmd_size", int'(cmd_size), e_size);
        chk("R6", "cmd_hdr", int'(cmd_hdr), e_hdr);
        chk("R7", "cmd_offset", int'(cmd_offset), e_off);
        chk("R4/R7", "desc_pop", int'(desc_pop), e_pop);
        chk("R8", "seg_valid", int'(seg_valid), e_close);
        chk("R13", "seg_last", int'(seg_last), e_last);
        chk("R9", "fix_id_inc", int'(fix_id_inc), e_id);
        chk("R10", "fix_ip_len", int'(fix_ip_len), e_iplen);
        chk("R11", "fix_seq_inc", int'(fix_seq_inc), e_seq);
        chk("R12", "fix_flag_mask", int'(fix_flag_mask), e_mask);
    endtask

    task automatic model_step();
        if (!m_act) begin
            if (ctx_valid) begin m_hdr = int'(ctx_hdr_len); m_mss = int'(ctx_mss); end
            if (desc_valid && desc_seg_en) begin
                m_act = 1; m_tot = int'(desc_total); m_used = 0; m_dused = 0;
                m_cur = 0; m_hh = 0; m_idx = 0; m_prev = 0;
            end
        end else if (e_go) begin
            m_used  = e_un;
            m_dused = e_pop ? 0 : m_dused + e_copy;
            if (e_close) begin
                m_cur = 0; m_hh = 0; m_idx++; m_prev = e_un;
            end else begin
                m_cur = e_nl; m_hh = 1;
            end
            if (e_last) m_act = 0;
        end
    endtask

    // One clock: set descriptor inputs, compare mid-cycle, step model at edge.
    task automatic cycle();
        desc_valid  = (dq.size() > 0);
        desc_len    = (dq.size() > 0) ? LEN_W'(dq[0]) : '0;
        desc_seg_en = first_pending;
        #(CLK_PERIOD/4);
        compare();
        @(posedge clk);
        model_step();
        if (e_pop) begin void'(dq.pop_front()); first_pending = 0; end
        @(negedge clk);
        ctx_valid = 1'b0;
    endtask

    task automatic load_ctx(input int h, input int m);
        ctx_valid = 1'b1; ctx_hdr_len = HDR_W'(h); ctx_mss = LEN_W'(m);
        cycle();
    endtask

    // Present a packet's descriptors; optionally pulse a context load mid-run (R2).
    task automatic run_packet(input int total, input int lens[$], input bit en, input int ctx_at);
        int k = 0;
        foreach (lens[i]) dq.push_back(lens[i]);
        first_pending = en;
        desc_total = TOT_W'(total);
        while ((dq.size() > 0 || m_act) && k < 200) begin
            if (k == ctx_at) begin ctx_valid = 1'b1; ctx_hdr_len = 8'd3; ctx_mss = 16'd7; end
            cycle();
            k++;
        end
        cycle();
        chk("R13", "idle after run", int'(busy), 0);
    endtask

    initial begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        compare();                         // R1: during reset
        chk("R1", "busy in reset", int'(busy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle();                           // R1: first cycle after reset
        // R2 R5 R8 R9 R10 R11 R12: one descriptor feeding three segments
        load_ctx(54, 100);
        run_packet(250, '{250}, 1'b1, -1);
        // R5 R6 R7: segments spanning descriptor boundaries; R2 ctx ignored while busy
        load_ctx(40, 100);
        run_packet(250, '{30, 80, 140}, 1'b1, 2);
        // R4: non-enabled descriptor in idle is popped without a command
        run_packet(0, '{64}, 1'b0, -1);
        // R12 R13: total an exact multiple of MSS
        load_ctx(20, 64);
        run_packet(128, '{50, 50, 28}, 1'b1, -1);
        // R8: single short segment
        run_packet(20, '{20}, 1'b1, -1);
        // R5: many one-byte descriptors
        load_ctx(14, 3);
        run_packet(7, '{1, 1, 1, 1, 1, 1, 1}, 1'b1, -1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule